// File: doc/BRIEF.md
# ISA Host Bus Cycle Sequencer

This block is the host-side control for one ISA bus cycle to a 16-bit memory or I/O target. It runs on a clock at twice the BCLK rate, so every BCLK period splits into a first half and a second half. The block generates its own BCLK reference from a free-running phase bit. Each cycle has one address period (Ts) followed by one or more data periods (Tc). A requester presents an address, a read/write flag, a memory/I/O flag and write data. The sequencer then drives BALE, the latched low address, the active-low command strobes and the write-data drive enable.

The target's 16-bit indication (`dev16_n`) is sampled twice. The first sample, at the end of Ts, decides whether a memory command can start at the beginning of the first Tc or must wait until its midpoint. The second sample, at the midpoint of the first Tc, reports whether byte steering is needed. An external ready timer ends the cycle through `end_cyc`, which is sampled in the second half of each Tc.

The upper address bits pass straight through unlatched, so the next address may appear early. Write data stays driven for half a BCLK after the cycle ends, which gives the target hold time.

The states, one per half-BCLK, are:
- IDLE (SQ_IDLE)
- Ts first half (SQ_ADR1)
- Ts second half with BALE high (SQ_ADR2)
- Tc first half (SQ_DAT1)
- Tc second half (SQ_DAT2)

The transitions are:
- IDLE→ADR1 on an accepted request
- ADR1→ADR2 and ADR2→DAT1 unconditionally
- DAT1→DAT2 unconditionally
- DAT2→DAT1 while `end_cyc` is low
- DAT2→ADR1 when `end_cyc` is high and a request is accepted
- DAT2→IDLE when `end_cyc` is high and no request is accepted

Top module: `isa_host_seq`

## Requirements
- R1: While `rst_n` is low, all four strobes are high, `bale` is low, `sd_oe` is low, `steer_needed` is low, `sa` is zero and `busy` is high.
- R2: `bclk` is high in the first half of every BCLK period. `busy` is low only in the second half, either while idle or in a final Tc half with `end_cyc` high. A request seen with `busy` low starts Ts (bclk high, bale low) on the next clock.
- R3: `bale` is high for exactly the second half of Ts and low at all other times.
- R4: `sa` shows the cycle's low LATCH_W address bits while `bale` is high. It holds that value after `bale` falls, through the end of the cycle and until the next cycle's `bale`.
- R5: `la` always equals the upper ADDR_W-LATCH_W bits of `req_addr`, whatever the state.
- R6: For a memory cycle with `dev16_n` low at the end of Ts, the command strobe is low from the start of the first Tc, and `steer_needed` becomes 0.
- R7: For any I/O cycle, or a memory cycle with `dev16_n` high at the end of Ts, the strobe goes low at the midpoint of the first Tc. `steer_needed` then takes the value of `dev16_n` at that midpoint and is not resampled in later Tc periods.
- R8: The strobe is chosen by {io, write}: 00 selects `mrd_n`, 01 `mwr_n`, 10 `iord_n` and 11 `iowr_n`. At most one strobe is low at a time.
- R9: `end_cyc` is sampled at the end of each Tc second half. While it is low, another Tc follows with the strobe still low. When it is high, the strobe is released on the next clock.
- R10: On a write, `sd_oe` rises with `bale` and `sd_out` shows the write data. Both are held through the first half after the cycle ends, even when the next cycle has already started. After that, `sd_oe` falls unless the new cycle is a write.
- R11: A request presented while `busy` is high is not taken. No new `bale` pulse occurs and `sa` keeps the running cycle's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the BCLK rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_wdata | input | DATA_W | Write data |
| end_cyc | input | 1 | Ready-timer terminate request |
| dev16_n | input | 1 | Target 16-bit indication, active low |
| busy | output | 1 | Request cannot be taken this clock |
| bclk | output | 1 | BCLK reference, high in first half |
| bale | output | 1 | Address latch enable |
| la | output | ADDR_W-LATCH_W | Unlatched upper address |
| sa | output | LATCH_W | Latched low address |
| mrd_n | output | 1 | Memory read strobe |
| mwr_n | output | 1 | Memory write strobe |
| iord_n | output | 1 | I/O read strobe |
| iowr_n | output | 1 | I/O write strobe |
| sd_out | output | DATA_W | Write data |
| sd_oe | output | 1 | Write data drive enable |
| steer_needed | output | 1 | Byte steering decision for the cycle |

## Verification
The hardest situation to reach is the pipelined hand-over. A new cycle has to be accepted in the very half-period where the ready timer ends a write, so that the old write data is still driven during the new Ts first half while `sa` still shows the old address. The stimulus gets there in a directed test. It raises `end_cyc` and `req_valid` together in the final Tc second half of a write, then checks `sd_out`, `sd_oe`, `sa` and the released strobe on each of the next two half-periods. The two `dev16_n` sampling points are reached by changing `dev16_n` between Ts and the first Tc in each table vector.

// File: rtl/isa_seq_pkg.sv
package isa_seq_pkg;

    // one state per half-BCLK period
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ADR1,
        SQ_ADR2,
        SQ_DAT1,
        SQ_DAT2
    } seq_state_e;

    localparam int unsigned N_STROBE = 4;
    localparam int unsigned KIND_W   = $clog2(N_STROBE);

    // strobe index = {io, write}
    localparam int unsigned SK_MRD  = 0;
    localparam int unsigned SK_MWR  = 1;
    localparam int unsigned SK_IORD = 2;
    localparam int unsigned SK_IOWR = 3;

endpackage

// File: rtl/isa_seq_fsm.sv
module isa_seq_fsm
    import isa_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       end_cyc,
    output seq_state_e state,
    output logic       phase,
    output logic       busy,
    output logic       accept
);

    seq_state_e st_q;
    seq_state_e st_d;
    logic       ph_q;
    logic       open_w;

    // state register and free-running half-period phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SQ_IDLE;
            ph_q <= 1'b0;
        end else begin
            st_q <= st_d;
            ph_q <= ~ph_q;
        end
    end

    // acceptance window: second half while idle, or final Tc half
    always_comb begin
        open_w = ((st_q == SQ_IDLE) && ph_q) ||
                 ((st_q == SQ_DAT2) && end_cyc);
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE: if (req_valid && open_w) st_d = SQ_ADR1;
            SQ_ADR1: st_d = SQ_ADR2;
            SQ_ADR2: st_d = SQ_DAT1;
            SQ_DAT1: st_d = SQ_DAT2;
            SQ_DAT2: begin
                if (end_cyc) st_d = req_valid ? SQ_ADR1 : SQ_IDLE;
                else         st_d = SQ_DAT1;
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        state  = st_q;
        phase  = ph_q;
        busy   = !open_w;
        accept = req_valid && open_w;
    end

endmodule

// File: rtl/isa_seq_cmd.sv
module isa_seq_cmd
    import isa_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  seq_state_e          state,
    input  logic                cur_write,
    input  logic                cur_io,
    input  logic                dev16_n,
    input  logic                end_cyc,
    output logic [N_STROBE-1:0] strobe_n,
    output logic                steer
);

    logic              on_q;
    logic              steer_q;
    logic              early_w;
    logic [KIND_W-1:0] kind_w;

    always_comb begin
        early_w = !cur_io && !dev16_n;
        kind_w  = {cur_io, cur_write};
    end

    // command on/off and steering decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q    <= 1'b0;
            steer_q <= 1'b0;
        end else begin
            case (state)
                SQ_ADR2: begin
                    // first sample at end of Ts
                    on_q <= early_w;
                    if (early_w) steer_q <= 1'b0;
                end
                SQ_DAT1: begin
                    // second sample at midpoint of first Tc only
                    if (!on_q) begin
                        on_q    <= 1'b1;
                        steer_q <= dev16_n;
                    end
                end
                SQ_DAT2: if (end_cyc) on_q <= 1'b0;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < N_STROBE; g++) begin : g_strobe
        assign strobe_n[g] = !(on_q && (kind_w == KIND_W'(g)));
    end

    assign steer = steer_q;

endmodule

// File: rtl/isa_seq_dpath.sv
module isa_seq_dpath
    import isa_seq_pkg::*;
#(
    parameter int unsigned LATCH_W = 20,
    parameter int unsigned DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  seq_state_e         state,
    input  logic               accept,
    input  logic [LATCH_W-1:0] req_addr_lo,
    input  logic               req_write,
    input  logic               req_io,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               cur_write,
    output logic               cur_io,
    output logic [LATCH_W-1:0] sa,
    output logic [DATA_W-1:0]  sd_out,
    output logic               sd_oe
);

    logic [LATCH_W-1:0] cur_lo_q;
    logic [DATA_W-1:0]  cur_wd_q;
    logic               cur_wr_q;
    logic               cur_io_q;
    logic [LATCH_W-1:0] sa_q;
    logic [DATA_W-1:0]  sd_q;
    logic               oe_q;

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_lo_q <= '0;
            cur_wd_q <= '0;
            cur_wr_q <= 1'b0;
            cur_io_q <= 1'b0;
        end else if (accept) begin
            cur_lo_q <= req_addr_lo;
            cur_wd_q <= req_wdata;
            cur_wr_q <= req_write;
            cur_io_q <= req_io;
        end
    end

    // low address latch: frozen on BALE fall
    always_ff @(posedge clk) begin
        if (!rst_n)                sa_q <= '0;
        else if (state == SQ_ADR2) sa_q <= cur_lo_q;
    end

    // write data drive with half-BCLK hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_q <= '0;
            oe_q <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: oe_q <= 1'b0;
                SQ_ADR1: begin
                    oe_q <= cur_wr_q;
                    if (cur_wr_q) sd_q <= cur_wd_q;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        sa        = (state == SQ_ADR2) ? cur_lo_q : sa_q;
        sd_out    = sd_q;
        sd_oe     = oe_q;
        cur_write = cur_wr_q;
        cur_io    = cur_io_q;
    end

endmodule

// File: rtl/isa_host_seq.sv
module isa_host_seq
    import isa_seq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 24,
    parameter int unsigned LATCH_W = 20,
    parameter int unsigned DATA_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic                      req_write,
    input  logic                      req_io,
    input  logic [DATA_W-1:0]         req_wdata,
    input  logic                      end_cyc,
    input  logic                      dev16_n,
    output logic                      busy,
    output logic                      bclk,
    output logic                      bale,
    output logic [ADDR_W-LATCH_W-1:0] la,
    output logic [LATCH_W-1:0]        sa,
    output logic                      mrd_n,
    output logic                      mwr_n,
    output logic                      iord_n,
    output logic                      iowr_n,
    output logic [DATA_W-1:0]         sd_out,
    output logic                      sd_oe,
    output logic                      steer_needed
);

    localparam int unsigned UP_W = ADDR_W - LATCH_W;

    seq_state_e          state_w;
    logic                phase_w;
    logic                accept_w;
    logic                cur_write_w;
    logic                cur_io_w;
    logic [N_STROBE-1:0] strobe_n_w;

    isa_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .end_cyc   (end_cyc),
        .state     (state_w),
        .phase     (phase_w),
        .busy      (busy),
        .accept    (accept_w)
    );

    isa_seq_dpath #(
        .LATCH_W (LATCH_W),
        .DATA_W  (DATA_W)
    ) u_dpath (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state_w),
        .accept      (accept_w),
        .req_addr_lo (req_addr[LATCH_W-1:0]),
        .req_write   (req_write),
        .req_io      (req_io),
        .req_wdata   (req_wdata),
        .cur_write   (cur_write_w),
        .cur_io      (cur_io_w),
        .sa          (sa),
        .sd_out      (sd_out),
        .sd_oe       (sd_oe)
    );

    isa_seq_cmd u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state_w),
        .cur_write (cur_write_w),
        .cur_io    (cur_io_w),
        .dev16_n   (dev16_n),
        .end_cyc   (end_cyc),
        .strobe_n  (strobe_n_w),
        .steer     (steer_needed)
    );

    always_comb begin
        bclk   = !phase_w;
        bale   = (state_w == SQ_ADR2);
        la     = req_addr[ADDR_W-1 -: UP_W];
        mrd_n  = strobe_n_w[SK_MRD];
        mwr_n  = strobe_n_w[SK_MWR];
        iord_n = strobe_n_w[SK_IORD];
        iowr_n = strobe_n_w[SK_IOWR];
    end

endmodule

// File: rtl/isa_host_seq_chk.sv
module isa_host_seq_chk #(
    parameter int unsigned LATCH_W = 20,
    parameter int unsigned DATA_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               end_cyc,
    input logic               busy,
    input logic               bclk,
    input logic               bale,
    input logic [LATCH_W-1:0] sa,
    input logic               mrd_n,
    input logic               mwr_n,
    input logic               iord_n,
    input logic               iowr_n,
    input logic [DATA_W-1:0]  sd_out,
    input logic               sd_oe
);

    logic [3:0] strb;
    assign strb = {iowr_n, iord_n, mwr_n, mrd_n};

    // R3
    bale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bale |=> !bale);

    // R3
    bale_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bale |-> !bclk);

    // R2
    open_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bclk);

    // R8
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~strb) <= 1);

    // R7
    io_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(iord_n) || $fell(iowr_n)) |-> !bclk);

    // R9
    strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&strb) && end_cyc && !bclk) |=> (&strb));

    // R4
    sa_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bale |-> $stable(sa));

    // R10
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_oe && $past(sd_oe) && !bale) |-> $stable(sd_out));

endmodule

bind isa_host_seq isa_host_seq_chk #(
    .LATCH_W (LATCH_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .end_cyc (end_cyc),
    .busy    (busy),
    .bclk    (bclk),
    .bale    (bale),
    .sa      (sa),
    .mrd_n   (mrd_n),
    .mwr_n   (mwr_n),
    .iord_n  (iord_n),
    .iowr_n  (iowr_n),
    .sd_out  (sd_out),
    .sd_oe   (sd_oe)
);

// File: tb/test_isa_host_seq.sv
module test_isa_host_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        end_cyc = 1'b0;
    logic        dev16_n = 1'b1;
    logic        busy, bclk, bale, sd_oe, steer_needed;
    logic [3:0]  la;
    logic [19:0] sa;
    logic        mrd_n, mwr_n, iord_n, iowr_n;
    logic [15:0] sd_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    isa_host_seq i_isa_host_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_io(req_io), .req_wdata(req_wdata),
        .end_cyc(end_cyc), .dev16_n(dev16_n), .busy(busy), .bclk(bclk),
        .bale(bale), .la(la), .sa(sa), .mrd_n(mrd_n), .mwr_n(mwr_n),
        .iord_n(iord_n), .iowr_n(iowr_n), .sd_out(sd_out), .sd_oe(sd_oe),
        .steer_needed(steer_needed)
    );

    // {wr, io, dev16 at Ts end, dev16 at Tc mid, n_tc[1:0], addr[23:0], data[15:0]}
    localparam logic [45:0] VECS [0:5] = '{
        {1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 24'hA12345, 16'h0000},
        {1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 24'h30F0F0, 16'hBEEF},
        {1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 24'h7ABCDE, 16'h0000},
        {1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 24'h0003F8, 16'h0000},
        {1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 24'h000278, 16'h5A5A},
        {1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 24'hFFFFFF, 16'h1234}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] strobes_exp(input logic on, input logic io, input logic wr);
        return on ? ~(4'b0001 << {io, wr}) : 4'hF;
    endfunction

    function automatic logic [3:0] strobes();
        return {iowr_n, iord_n, mwr_n, mrd_n};
    endfunction

    task automatic wait_open();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // one full cycle from idle, checked on every half period
    task automatic run_vec(input logic [45:0] v);
        logic wr, io, dts, dmid, early;
        logic [1:0] ntc;
        logic [23:0] ad;
        logic [15:0] wd;
        {wr, io, dts, dmid, ntc, ad, wd} = v;
        early = !io && !dts;
        wait_open();
        chk("R2 open in second half", {31'd0, bclk}, 32'd0);
        req_valid = 1'b1; req_addr = ad; req_write = wr; req_io = io; req_wdata = wd;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk("R2 Ts starts bclk high", {31'd0, bclk}, 32'd1);
        chk("R3 bale low Ts first half", {31'd0, bale}, 32'd0);
        chk("R8 strobes idle in Ts", {28'd0, strobes()}, 32'hF);
        dev16_n = dts;
        @(posedge clk); @(negedge clk);
        chk("R3 bale high Ts second half", {31'd0, bale}, 32'd1);
        chk("R4 sa shows address", {12'd0, sa}, {12'd0, ad[19:0]});
        chk("R10 sd_oe in Ts", {31'd0, sd_oe}, {31'd0, wr});
        if (wr) chk("R10 sd_out data", {16'd0, sd_out}, {16'd0, wd});
        @(posedge clk); @(negedge clk);
        chk("R3 bale low in Tc", {31'd0, bale}, 32'd0);
        chk(early ? "R6 early strobe" : "R7 no strobe first half",
            {28'd0, strobes()}, {28'd0, strobes_exp(early, io, wr)});
        dev16_n = dmid;
        for (int k = 0; k < ntc; k++) begin
            if (k > 0) begin
                @(posedge clk); @(negedge clk);
                chk("R9 strobe held in extra Tc", {28'd0, strobes()},
                    {28'd0, strobes_exp(1'b1, io, wr)});
            end
            @(posedge clk); @(negedge clk);
            chk("R8 strobe select mid Tc", {28'd0, strobes()},
                {28'd0, strobes_exp(1'b1, io, wr)});
            chk(early ? "R6 steer zero" : "R7 steer sample", {31'd0, steer_needed},
                {31'd0, early ? 1'b0 : dmid});
            chk("R4 sa held", {12'd0, sa}, {12'd0, ad[19:0]});
            dev16_n = ~dmid;  // later Tc must not resample (R7)
            end_cyc = (k == ntc - 1);
            #1;
            chk("R2 busy until final half", {31'd0, busy}, {31'd0, !end_cyc});
        end
        @(posedge clk); @(negedge clk);
        end_cyc = 1'b0;
        chk("R9 strobe released", {28'd0, strobes()}, 32'hF);
        chk("R7 steer not resampled", {31'd0, steer_needed},
            {31'd0, early ? 1'b0 : dmid});
        chk("R10 write hold half", {31'd0, sd_oe}, {31'd0, wr});
        @(posedge clk); @(negedge clk);
        chk("R10 drive off after hold", {31'd0, sd_oe}, 32'd0);
        chk("R4 sa held after cycle", {12'd0, sa}, {12'd0, ad[19:0]});
        dev16_n = 1'b1;
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 strobes", {28'd0, strobes()}, 32'hF);
        chk("R1 bale", {31'd0, bale}, 32'd0);
        chk("R1 sd_oe", {31'd0, sd_oe}, 32'd0);
        chk("R1 steer", {31'd0, steer_needed}, 32'd0);
        chk("R1 sa", {12'd0, sa}, 32'd0);
        chk("R1 busy", {31'd0, busy}, 32'd1);
        rst_n = 1'b1;

        for (int i = 0; i < 6; i++) run_vec(VECS[i]);

        // R5 upper address passthrough while idle
        req_addr = 24'hC00000; #1;
        chk("R5 la passthrough", {28'd0, la}, 32'hC);
        req_addr = 24'h500000; #1;
        chk("R5 la follows", {28'd0, la}, 32'h5);

        // R10 / R4 pipelined hand-over: write then read accepted in last half
        wait_open();
        req_valid = 1'b1; req_addr = 24'h111111; req_write = 1'b1; req_io = 1'b0;
        req_wdata = 16'hCAFE; dev16_n = 1'b0;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); @(negedge clk);   // Ts second half
        @(posedge clk); @(negedge clk);   // Tc first half
        @(posedge clk); @(negedge clk);   // Tc second half
        end_cyc = 1'b1; req_valid = 1'b1; req_addr = 24'h922222; req_write = 1'b0;
        req_wdata = 16'h0000; dev16_n = 1'b1; #1;
        chk("R2 open at final half", {31'd0, busy}, 32'd0);
        chk("R5 next la early", {28'd0, la}, 32'h9);
        @(posedge clk); @(negedge clk);   // new Ts first half
        end_cyc = 1'b0; req_valid = 1'b0;
        chk("R10 old data held", {16'd0, sd_out}, 32'hCAFE);
        chk("R10 oe held", {31'd0, sd_oe}, 32'd1);
        chk("R4 old sa held", {12'd0, sa}, 32'h11111);
        chk("R9 write strobe off", {28'd0, strobes()}, 32'hF);
        @(posedge clk); @(negedge clk);   // new Ts second half
        chk("R10 oe off for read", {31'd0, sd_oe}, 32'd0);
        chk("R4 new sa", {12'd0, sa}, 32'h22222);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        chk("R7 late read strobe", {28'd0, strobes()}, 32'hE);
        end_cyc = 1'b1;
        @(posedge clk); @(negedge clk);
        end_cyc = 1'b0;

        // R11 request held while busy is not taken
        wait_open();
        req_valid = 1'b1; req_addr = 24'h0ABCDE; req_write = 1'b0; req_io = 1'b0;
        dev16_n = 1'b0;
        @(posedge clk); @(negedge clk);
        req_addr = 24'h055555;            // held request, new address
        for (int h = 0; h < 5; h++) begin
            chk("R11 busy mid cycle", {31'd0, busy}, 32'd1);
            @(posedge clk); @(negedge clk);
            if (h >= 1) chk("R11 no extra bale", {31'd0, bale}, 32'd0);
        end
        // now in second Tc second half
        chk("R11 sa keeps running address", {12'd0, sa}, 32'hABCDE);
        req_valid = 1'b0; end_cyc = 1'b1;
        @(posedge clk); @(negedge clk);
        end_cyc = 1'b0;
        chk("R11 idle strobes", {28'd0, strobes()}, 32'hF);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        chk("R11 no new cycle", {31'd0, bale}, 32'd0);

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule